// File: doc/BRIEF.md
# Pipelined Unsigned Array Multiplier

This block multiplies two K-bit unsigned operands and returns their 2K-bit product. It is built as a grid of carry-save cells. Each cell ANDs one multiplicand bit with one multiplier bit and feeds that partial-product bit into a full adder, together with the sum and carry that come down from the previous row. Each partial-product row finishes one low product bit. A last row of full adders wired as a ripple-carry chain adds the remaining sum and carry vectors into the upper half of the product.

A register bank follows every row. The multiplicand, the multiplier bits that later rows still need, and the low product bits already finished all move through these banks beside the carry-save state, so each operation stays aligned with its own data. A new operand pair can enter on every clock cycle. A valid flag moves with the data and marks each result when it leaves the last bank. The default size is K = 5, which gives a 10-bit product.

Top module: `umul_array_pipe`

## Requirements
- R1: When `out_valid` is high, `out_prod` equals the unsigned product of the `in_a` and `in_b` values that were sampled for that operation, over the full 2K bits.
- R2: An operand pair sampled with `in_valid` high at a rising edge produces its result with `out_valid` high after the K-th rising edge that follows. This gives K+1 register stages in total, which is 6 edges for K = 5.
- R3: Pairs applied on consecutive cycles produce results on consecutive cycles, in the order they were applied, each one correct.
- R4: `out_valid` is high only in cycles that match an input cycle with `in_valid` high. Operands presented while `in_valid` is low never produce a valid result, and the valid results around them are unaffected.
- R5: Extreme operands are exact. A zero operand on either side gives a product of 0. All ones times all ones gives 2^(2K) - 2^(K+1) + 1, which is 961 for K = 5.
- R6: Reset is synchronous and active high. After a rising edge with `rst` high, `out_valid` is 0 and `out_prod` is 0. Operations in flight at reset are discarded, and none of them appears after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous active-high reset for every stage |
| in_valid | input | 1 | Marks the operand pair on this cycle as an operation |
| in_a | input | K | Multiplicand, unsigned |
| in_b | input | K | Multiplier, unsigned |
| out_valid | output | 1 | High when `out_prod` holds a finished result |
| out_prod | output | 2K | Registered unsigned product |

## Verification
The hardest case to reach from the ports is a pipeline in which every stage holds a different operation while the validity pattern changes from cycle to cycle. A misaligned operand or low-product delay register only shows up when neighbouring stages hold different data. To reach this state, the stimulus first streams corner operands and long runs of random pairs with no gaps. It then interleaves random bubbles that carry random operand values, and finally asserts reset while the pipeline is full to show that the in-flight work is discarded. A scoreboard tags each expected product with the cycle in which it is due, so an early, late, missing or extra result is reported against its own requirement.

// File: rtl/umul_pkg.sv
package umul_pkg;

  typedef struct packed {
    logic co;
    logic s;
  } fa_res_t;

  // one-bit full adder: x + y + ci = 2*co + s
  function automatic fa_res_t fa_add(input logic x, input logic y, input logic ci);
    fa_res_t r;
    r.s  = x ^ y ^ ci;
    r.co = (x & y) | (ci & (x ^ y));
    return r;
  endfunction

endpackage

// File: rtl/umul_cell.sv
module umul_cell
  import umul_pkg::*;
(
  input  logic a_bit,
  input  logic x_bit,
  input  logic s_in,
  input  logic c_in,
  output logic s_out,
  output logic c_out
);

  fa_res_t res;

  assign res   = fa_add(a_bit & x_bit, s_in, c_in);
  assign s_out = res.s;
  assign c_out = res.co;

endmodule

// File: rtl/umul_row.sv
// One partial-product row: K cells, then a register bank.
// Sum/carry vectors are aligned to weight 2^IDX on input, 2^(IDX+1) on output.
module umul_row #(
  parameter int K   = 5,
  parameter int IDX = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         v_i,
  input  logic [K-1:0] a_i,
  input  logic         xb_i,
  input  logic [K-1:0] s_i,
  input  logic [K-1:0] c_i,
  input  logic [K-1:0] lo_i,
  output logic         v_o,
  output logic [K-1:0] s_o,
  output logic [K-1:0] c_o,
  output logic [K-1:0] lo_o
);

  logic [K-1:0] cs;
  logic [K-1:0] cc;
  logic [K-1:0] s_nx;
  logic [K-1:0] lo_nx;

  for (genvar m = 0; m < K; m++) begin : g_cell
    umul_cell u_cell (
      .a_bit (a_i[m]),
      .x_bit (xb_i),
      .s_in  (s_i[m]),
      .c_in  (c_i[m]),
      .s_out (cs[m]),
      .c_out (cc[m])
    );
  end

  always_comb begin
    s_nx       = {1'b0, cs[K-1:1]};
    lo_nx      = lo_i;
    lo_nx[IDX] = cs[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_o  <= 1'b0;
      s_o  <= '0;
      c_o  <= '0;
      lo_o <= '0;
    end else begin
      v_o  <= v_i;
      s_o  <= s_nx;
      c_o  <= cc;
      lo_o <= lo_nx;
    end
  end

endmodule

// File: rtl/umul_cpa.sv
// Final row: ripple of full adders resolving the carry-save pair, then the output register.
module umul_cpa
  import umul_pkg::*;
#(
  parameter int K = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           v_i,
  input  logic [K-1:0]   s_i,
  input  logic [K-1:0]   c_i,
  input  logic [K-1:0]   lo_i,
  output logic           v_o,
  output logic [2*K-1:0] p_o
);

  logic [K-1:0] hi;
  logic         carry;
  fa_res_t      fr;

  always_comb begin
    carry = 1'b0;
    fr    = '0;
    hi    = '0;
    for (int m = 0; m < K; m++) begin
      fr    = fa_add(s_i[m], c_i[m], carry);
      hi[m] = fr.s;
      carry = fr.co;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_o <= 1'b0;
      p_o <= '0;
    end else begin
      v_o <= v_i;
      p_o <= {hi, lo_i};
    end
  end

endmodule

// File: rtl/umul_array_pipe.sv
module umul_array_pipe #(
  parameter int K = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [K-1:0]     in_a,
  input  logic [K-1:0]     in_b,
  output logic             out_valid,
  output logic [2*K-1:0]   out_prod
);

  localparam int PW = 2 * K;

  logic         v_q  [0:K];
  logic [K-1:0] s_q  [0:K];
  logic [K-1:0] c_q  [0:K];
  logic [K-1:0] lo_q [0:K];

  assign v_q[0]  = in_valid;
  assign s_q[0]  = '0;
  assign c_q[0]  = '0;
  assign lo_q[0] = '0;

  // Stage r: operands seen by row r. Multiplier bits already consumed are dropped.
  for (genvar r = 0; r < K; r++) begin : g_op
    logic [K-1:0]   aq;
    logic [K-1-r:0] xq;

    if (r == 0) begin : g_head
      assign aq = in_a;
      assign xq = in_b;
    end else begin : g_dly
      always_ff @(posedge clk) begin
        if (rst) begin
          aq <= '0;
          xq <= '0;
        end else begin
          aq <= g_op[r-1].aq;
          xq <= g_op[r-1].xq[K-r:1];
        end
      end
    end

    umul_row #(
      .K   (K),
      .IDX (r)
    ) u_row (
      .clk  (clk),
      .rst  (rst),
      .v_i  (v_q[r]),
      .a_i  (aq),
      .xb_i (xq[0]),
      .s_i  (s_q[r]),
      .c_i  (c_q[r]),
      .lo_i (lo_q[r]),
      .v_o  (v_q[r+1]),
      .s_o  (s_q[r+1]),
      .c_o  (c_q[r+1]),
      .lo_o (lo_q[r+1])
    );
  end

  logic [PW-1:0] prod_q;
  logic          vout_q;

  umul_cpa #(
    .K (K)
  ) u_cpa (
    .clk  (clk),
    .rst  (rst),
    .v_i  (v_q[K]),
    .s_i  (s_q[K]),
    .c_i  (c_q[K]),
    .lo_i (lo_q[K]),
    .v_o  (vout_q),
    .p_o  (prod_q)
  );

  assign out_valid = vout_q;
  assign out_prod  = prod_q;

endmodule

// File: rtl/umul_array_pipe_chk.sv
module umul_array_pipe_chk #(
  parameter int K = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [K-1:0]   in_a,
  input logic [K-1:0]   in_b,
  input logic           out_valid,
  input logic [2*K-1:0] out_prod
);

  localparam int PW = 2 * K;

  logic [K:0]    vq;
  logic [PW-1:0] pq [0:K];

  always_ff @(posedge clk) begin
    if (rst) begin
      vq <= '0;
      for (int j = 0; j <= K; j++) pq[j] <= '0;
    end else begin
      vq    <= {vq[K-1:0], in_valid};
      pq[0] <= PW'(in_a) * PW'(in_b);
      for (int j = 1; j <= K; j++) pq[j] <= pq[j-1];
    end
  end

  // R2 and R4: valid leaves exactly K+1 edges after it entered, never otherwise
  assert_valid_track_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid == vq[K]);

  assert_product_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_prod == pq[K]));

  assert_defined_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !$isunknown(out_prod));

  assert_reset_clear_R6: assert property (@(posedge clk)
    rst |=> (!out_valid && out_prod == '0));

endmodule

bind umul_array_pipe umul_array_pipe_chk #(.K(K)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_a      (in_a),
  .in_b      (in_b),
  .out_valid (out_valid),
  .out_prod  (out_prod)
);

// File: tb/umul_array_pipe_tb.sv
`timescale 1ns/1ps
module umul_array_pipe_tb;

  localparam int K  = 5;
  localparam int PW = 2 * K;
  localparam int MAXV = (1 << K) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [K-1:0]  in_a = '0;
  logic [K-1:0]  in_b = '0;
  logic          out_valid;
  logic [PW-1:0] out_prod;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    logic [PW-1:0] exp;
    int            due;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  umul_array_pipe #(.K(K)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_prod  (out_prod)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Driver: captured at the next edge; result due K edges after that one.
  task automatic drive(input bit v, input logic [K-1:0] a, input logic [K-1:0] b);
    item_t it;
    @(negedge clk);
    in_valid = v;
    in_a     = a;
    in_b     = b;
    if (v) begin
      it.exp = PW'(a) * PW'(b);
      it.due = cyc + 1 + K;
      sb.push_back(it);
    end
  endtask

  // Monitor: compares at the falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (sb.size() != 0 && sb[0].due == cyc) begin
        check(out_valid == 1'b1, "R2 result present at its latency", longint'(out_valid), 1);
        check(out_prod == sb[0].exp, "R1/R3 product value and order",
              longint'(out_prod), longint'(sb[0].exp));
        void'(sb.pop_front());
      end else begin
        check(out_valid == 1'b0, "R4 no valid without a matching input", longint'(out_valid), 0);
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    // Reset with garbage valid input present (R6)
    in_valid = 1'b1;
    in_a = '1;
    in_b = '1;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b0, "R6 valid cleared in reset", longint'(out_valid), 0);
    check(out_prod == '0, "R6 product cleared in reset", longint'(out_prod), 0);
    rst = 1'b0;

    // Corner operands back to back (R5, R3)
    drive(1, '0, '0);
    drive(1, MAXV[K-1:0], MAXV[K-1:0]);
    drive(1, '0, MAXV[K-1:0]);
    drive(1, MAXV[K-1:0], '0);
    drive(1, 1, MAXV[K-1:0]);
    drive(1, MAXV[K-1:0], 1);
    drive(1, 1 << (K-1), 1 << (K-1));
    begin
      logic [PW-1:0] r5_top;
      r5_top = PW'(MAXV) * PW'(MAXV);
      check(r5_top == PW'(961), "R5 all-ones reference for K=5", longint'(r5_top), 961);
    end

    // Long back-to-back random stream (R1, R3)
    for (int i = 0; i < 200; i++)
      drive(1, K'($urandom_range(0, MAXV)), K'($urandom_range(0, MAXV)));

    // Bubbles carrying random operands (R4)
    for (int i = 0; i < 300; i++)
      drive(($urandom_range(0, 2) != 0), K'($urandom_range(0, MAXV)),
            K'($urandom_range(0, MAXV)));

    // Alternating valid / invalid with all-ones on the invalid cycles (R4)
    for (int i = 0; i < 20; i++) begin
      drive(1, K'(i), K'(MAXV - i));
      drive(0, MAXV[K-1:0], MAXV[K-1:0]);
    end

    // Drain
    repeat (K + 3) drive(0, '0, '0);
    check(sb.size() == 0, "R3 every queued result delivered", sb.size(), 0);

    // Reset while the pipeline is full (R6)
    for (int i = 0; i < K; i++) drive(1, MAXV[K-1:0], K'(i + 1));
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    sb.delete();
    @(negedge clk);
    check(out_valid == 1'b0, "R6 valid cleared after reset edge", longint'(out_valid), 0);
    check(out_prod == '0, "R6 product cleared after reset edge", longint'(out_prod), 0);
    @(negedge clk);
    rst = 1'b0;
    repeat (K + 4) drive(0, MAXV[K-1:0], MAXV[K-1:0]);

    // Restart after reset (R1, R2)
    drive(1, 3, 7);
    drive(1, MAXV[K-1:0], MAXV[K-1:0]);
    repeat (K + 3) drive(0, '0, '0);
    check(sb.size() == 0, "R2 results after reset delivered", sb.size(), 0);

    done = 1;
    summary();
    $finish;
  end

endmodule